// File: doc/BRIEF.md
# Flash erase and program-write gating registers

This unit sits on the special-function-register bus of a small microcontroller and stands between software and the flash macro. It holds three registers: an erase command register, a page number register and a flash control register. An erase reaches the flash only when software performs a fixed sequence. Software first makes an arming write, then writes a magic command byte. The unit then sends a one-clock start pulse to the flash interface. A page erase carries its page number with the pulse.

The flash control register holds three bits. The program-write enable makes the core send its external-data writes into program flash; it clears itself once the flash reports that a byte has been written. The mass-erase enable arms a whole-array erase. The security bit can be set but never cleared by software. While it is set, an output blocks external readout of the flash.

Top module: `flash_gate_sfr`

## Requirements
- R1: After synchronous reset, page_erase_go, mass_erase_go, erase_page, prog_wr_en and secure_lock are all 0, and reads of all three registers return 0.
- R2: A write to the page register (address 0xB7) stores the page as sfr_wdata[7:1]. A read returns {page, 1'b0}. sfr_rdata is registered and is valid in the cycle after sfr_rd.
- R3: Writing 0x55 to the command register (address 0x94) after a page register write gives page_erase_go high for exactly one cycle, in the cycle after the write, with erase_page equal to the stored page. This uses up the arming, so a second 0x55 with no new page write does nothing.
- R4: Writing 0x55 when no page register write has happened since the last page erase started gives no pulse.
- R5: Writing 0xAA to the command register gives mass_erase_go high for one cycle only when two things hold: the last control register write (address 0xB2) had bit 1 set, and dbg_en is high. A started mass erase uses up that arming. With either condition missing there is no pulse.
- R6: Any command value other than 0x55 or 0xAA gives no pulse and leaves both armings intact.
- R7: A command write while fl_busy is high gives no pulse and leaves both armings intact.
- R8: A control register write loads prog_wr_en from bit 0 when ints_on is low. When ints_on is high, prog_wr_en is unchanged.
- R9: fl_byte_done clears prog_wr_en in the next cycle, and it wins over a write in the same cycle.
- R10: Writing 1 to control bit 6 sets secure_lock. Writing 0 there is ignored, and only reset clears it.
- R11: Reads of the command register return 0x00. In a control register read, bit 1 reads 0, bit 0 is prog_wr_en, bit 6 is secure_lock, and the other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Registered read data |
| ints_on | input | 1 | Global interrupt enable from the core |
| dbg_en | input | 1 | Debug port enabled |
| fl_busy | input | 1 | Flash macro busy |
| fl_byte_done | input | 1 | Flash reports one byte programmed |
| page_erase_go | output | 1 | One-cycle page erase start |
| mass_erase_go | output | 1 | One-cycle mass erase start |
| erase_page | output | 7 | Page number for page erase |
| prog_wr_en | output | 1 | Route data-move writes to program flash |
| secure_lock | output | 1 | Block external flash readout |

## Verification
On every cycle, the assertions check the following. An erase pulse never lasts more than one cycle, and the two pulses never overlap. A mass erase never starts without the debug port. A command written while busy is always dropped. The security latch never falls. prog_wr_en holds while interrupts are on and drops after a byte-done strobe. Only the bench scenarios can show the rest. Arming is used up and not just checked. Rejected command values keep the arming. The page number on the pulse matches the page written. Read-back encodings are correct.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'h55;
  localparam logic [7:0] CMD_MASS_ERASE = 8'hAA;
  localparam int CTL_PWE_BIT  = 0;
  localparam int CTL_MEEN_BIT = 1;
  localparam int CTL_SEC_BIT  = 6;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_CMD  = 2'd1,
    RSEL_PAGE = 2'd2,
    RSEL_CTL  = 2'd3
  } rsel_t;
endpackage

// File: rtl/fg_decode.sv
module fg_decode
  import flash_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h94,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hB2
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_cmd,
  output logic              wr_page,
  output logic              wr_ctl,
  output rsel_t             rsel
);
  always_comb begin
    wr_cmd  = wr && (addr == CMD_ADDR);
    wr_page = wr && (addr == PAGE_ADDR);
    wr_ctl  = wr && (addr == CTL_ADDR);
    if (addr == CMD_ADDR)       rsel = RSEL_CMD;
    else if (addr == PAGE_ADDR) rsel = RSEL_PAGE;
    else if (addr == CTL_ADDR)  rsel = RSEL_CTL;
    else                        rsel = RSEL_NONE;
  end
endmodule

// File: rtl/fg_erase_seq.sv
module fg_erase_seq
  import flash_gate_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic              wr_page,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dbg_en,
  input  logic              fl_busy,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_go,
  output logic              mass_go,
  output logic [PAGE_W-1:0] erase_page
);
  logic page_armed, mass_armed;
  logic start_page, start_mass;

  always_comb begin
    start_page = wr_cmd && !fl_busy && page_armed &&
                 (wdata == CMD_PAGE_ERASE[DATA_W-1:0]);
    start_mass = wr_cmd && !fl_busy && mass_armed && dbg_en &&
                 (wdata == CMD_MASS_ERASE[DATA_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q     <= '0;
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
      page_go    <= 1'b0;
      mass_go    <= 1'b0;
      erase_page <= '0;
    end else begin
      page_go <= start_page;
      mass_go <= start_mass;
      if (start_page) erase_page <= page_q;
      if (wr_page) begin
        page_q     <= wdata[PAGE_W:1];
        page_armed <= 1'b1;
      end else if (start_page) begin
        page_armed <= 1'b0;
      end
      if (wr_ctl)          mass_armed <= wdata[CTL_MEEN_BIT];
      else if (start_mass) mass_armed <= 1'b0;
    end
  end
endmodule

// File: rtl/fg_ctl_bits.sv
module fg_ctl_bits (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctl,
  input  logic pwe_in,
  input  logic sec_in,
  input  logic ints_on,
  input  logic byte_done,
  output logic pwe,
  output logic secure
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwe    <= 1'b0;
      secure <= 1'b0;
    end else begin
      if (byte_done)                 pwe <= 1'b0;
      else if (wr_ctl && !ints_on)   pwe <= pwe_in;
      if (wr_ctl && sec_in)          secure <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_gate_sfr.sv
module flash_gate_sfr
  import flash_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h94,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hB2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              ints_on,
  input  logic              dbg_en,
  input  logic              fl_busy,
  input  logic              fl_byte_done,
  output logic              page_erase_go,
  output logic              mass_erase_go,
  output logic [DATA_W-2:0] erase_page,
  output logic              prog_wr_en,
  output logic              secure_lock
);
  localparam int PAGE_W = DATA_W - 1;

  logic wr_cmd, wr_page, wr_ctl;
  rsel_t rsel;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] rd_next;

  fg_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .PAGE_ADDR(PAGE_ADDR),
              .CTL_ADDR(CTL_ADDR)) dec_i (
    .wr(sfr_wr), .addr(sfr_addr), .wr_cmd(wr_cmd), .wr_page(wr_page),
    .wr_ctl(wr_ctl), .rsel(rsel));

  fg_erase_seq #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) seq_i (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_page(wr_page), .wr_ctl(wr_ctl),
    .wdata(sfr_wdata), .dbg_en(dbg_en), .fl_busy(fl_busy), .page_q(page_q),
    .page_go(page_erase_go), .mass_go(mass_erase_go), .erase_page(erase_page));

  fg_ctl_bits ctl_i (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .pwe_in(sfr_wdata[CTL_PWE_BIT]),
    .sec_in(sfr_wdata[CTL_SEC_BIT]), .ints_on(ints_on),
    .byte_done(fl_byte_done), .pwe(prog_wr_en), .secure(secure_lock));

  always_comb begin
    rd_next = '0;
    case (rsel)
      RSEL_PAGE: rd_next = {page_q, 1'b0};
      RSEL_CTL: begin
        rd_next[CTL_PWE_BIT] = prog_wr_en;
        rd_next[CTL_SEC_BIT] = secure_lock;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         sfr_rdata <= '0;
    else if (sfr_rd) sfr_rdata <= rd_next;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h94,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hB2
) (
  input logic              clk,
  input logic              rst,
  input logic              sfr_wr,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic              ints_on,
  input logic              dbg_en,
  input logic              fl_busy,
  input logic              fl_byte_done,
  input logic              page_erase_go,
  input logic              mass_erase_go,
  input logic              prog_wr_en,
  input logic              secure_lock
);
  assert_page_pulse_one_R3: assert property (@(posedge clk) disable iff (rst)
    page_erase_go |=> !page_erase_go);
  assert_mass_pulse_one_R5: assert property (@(posedge clk) disable iff (rst)
    mass_erase_go |=> !mass_erase_go);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(page_erase_go && mass_erase_go));
  assert_mass_needs_dbg_R5: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr && sfr_addr == CMD_ADDR && !dbg_en) |=> !mass_erase_go);
  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr && sfr_addr == CMD_ADDR && fl_busy) |=> (!page_erase_go && !mass_erase_go));
  assert_pwe_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (ints_on && !fl_byte_done) |=> $stable(prog_wr_en));
  assert_pwe_clear_R9: assert property (@(posedge clk) disable iff (rst)
    fl_byte_done |=> !prog_wr_en);
  assert_secure_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    secure_lock |=> secure_lock);
  assert_secure_set_R10: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr && sfr_addr == CTL_ADDR && sfr_wdata[6]) |=> secure_lock);
endmodule

bind flash_gate_sfr fg_checker chk_i (
  .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .ints_on(ints_on), .dbg_en(dbg_en),
  .fl_busy(fl_busy), .fl_byte_done(fl_byte_done),
  .page_erase_go(page_erase_go), .mass_erase_go(mass_erase_go),
  .prog_wr_en(prog_wr_en), .secure_lock(secure_lock));

// File: tb/flash_gate_sfr_tb_top.sv
module flash_gate_sfr_tb_top;
  localparam logic [7:0] A_CMD = 8'h94, A_PAGE = 8'hB7, A_CTL = 8'hB2;

  logic clk = 1'b0, rst = 1'b1;
  logic sfr_wr = 0, sfr_rd = 0, ints_on = 0, dbg_en = 0, fl_busy = 0, fl_byte_done = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic page_erase_go, mass_erase_go, prog_wr_en, secure_lock;
  logic [6:0] erase_page;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_gate_sfr dut_i (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ints_on(ints_on),
    .dbg_en(dbg_en), .fl_busy(fl_busy), .fl_byte_done(fl_byte_done),
    .page_erase_go(page_erase_go), .mass_erase_go(mass_erase_go),
    .erase_page(erase_page), .prog_wr_en(prog_wr_en), .secure_lock(secure_lock));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_rd = 1; sfr_addr = a;
    @(negedge clk); sfr_rd = 0; d = sfr_rdata;
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pulses", {page_erase_go, mass_erase_go}, 0);
    chk("R1 page", erase_page, 0);
    chk("R1 bits", {prog_wr_en, secure_lock}, 0);
    rd(A_CMD, r);  chk("R1 cmd read", r, 0);
    rd(A_PAGE, r); chk("R1 page read", r, 0);
    rd(A_CTL, r);  chk("R1 ctl read", r, 0);
    // R4 unarmed page erase
    wr(A_CMD, 8'h55); chk("R4 no pulse", page_erase_go, 0);
    // R2 R3 full page sweep
    for (int p = 0; p < 128; p++) begin
      wr(A_PAGE, {p[6:0], 1'b1});
      rd(A_PAGE, r); chk("R2 readback", r, {p[6:0], 1'b0});
      wr(A_CMD, 8'h55);
      chk("R3 pulse", page_erase_go, 1);
      chk("R3 page", erase_page, p[6:0]);
      idle; chk("R3 one cycle", page_erase_go, 0);
      wr(A_CMD, 8'h55); chk("R3 consumed", page_erase_go, 0);
    end
    // R5 mass erase conditions
    dbg_en = 0; wr(A_CTL, 8'h02); wr(A_CMD, 8'hAA); chk("R5 no dbg", mass_erase_go, 0);
    dbg_en = 1; wr(A_CMD, 8'hAA); chk("R5 pulse", mass_erase_go, 1);
    idle; chk("R5 one cycle", mass_erase_go, 0);
    wr(A_CMD, 8'hAA); chk("R5 consumed", mass_erase_go, 0);
    wr(A_CTL, 8'h02); wr(A_CTL, 8'h00); wr(A_CMD, 8'hAA); chk("R5 disarmed", mass_erase_go, 0);
    // R6 sweep all other command values with both armings in place
    wr(A_PAGE, 8'h0A); wr(A_CTL, 8'h02);
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h55 && v != 8'hAA) begin
        wr(A_CMD, v[7:0]);
        chk("R6 no pulse", {page_erase_go, mass_erase_go}, 0);
      end
    end
    wr(A_CMD, 8'h55); chk("R6 page arming kept", page_erase_go, 1); chk("R6 page", erase_page, 7'd5);
    wr(A_CMD, 8'hAA); chk("R6 mass arming kept", mass_erase_go, 1);
    // R7 busy
    wr(A_PAGE, 8'h20); wr(A_CTL, 8'h02);
    fl_busy = 1;
    wr(A_CMD, 8'h55); chk("R7 page dropped", page_erase_go, 0);
    wr(A_CMD, 8'hAA); chk("R7 mass dropped", mass_erase_go, 0);
    fl_busy = 0;
    wr(A_CMD, 8'h55); chk("R7 page kept", page_erase_go, 1); chk("R7 page", erase_page, 7'h10);
    wr(A_CMD, 8'hAA); chk("R7 mass kept", mass_erase_go, 1);
    // R8 program write enable
    ints_on = 1; wr(A_CTL, 8'h01); chk("R8 locked", prog_wr_en, 0);
    ints_on = 0; wr(A_CTL, 8'h01); chk("R8 set", prog_wr_en, 1);
    ints_on = 1; wr(A_CTL, 8'h00); chk("R8 locked hold", prog_wr_en, 1);
    // R11 control read
    wr(A_PAGE, 8'h00); wr(A_CTL, 8'h02);
    rd(A_CTL, r); chk("R11 ctl read", r, 8'h01);
    rd(A_CMD, r); chk("R11 cmd read", r, 8'h00);
    // R9 byte done
    @(negedge clk); fl_byte_done = 1; @(negedge clk); fl_byte_done = 0;
    chk("R9 cleared", prog_wr_en, 0);
    ints_on = 0; wr(A_CTL, 8'h01); chk("R9 rearm", prog_wr_en, 1);
    @(negedge clk); fl_byte_done = 1; sfr_wr = 1; sfr_addr = A_CTL; sfr_wdata = 8'h01;
    @(negedge clk); fl_byte_done = 0; sfr_wr = 0;
    chk("R9 priority", prog_wr_en, 0);
    // R10 security
    wr(A_CTL, 8'h40); chk("R10 set", secure_lock, 1);
    wr(A_CTL, 8'h00); chk("R10 sticky", secure_lock, 1);
    rd(A_CTL, r); chk("R11 sec read", r, 8'h40);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R10 reset clears", secure_lock, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule